// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital timing controller of a 10-bit successive-approximation converter. Two software-visible control bits drive it: a converter enable, given as a level, and a conversion start, given as a write strobe with a value. A 2-bit divider select and a 1-bit speed select pick the timing. From the system clock the block derives a conversion clock. Each conversion starts with a sampling window, during which a strobe to the analog front end is raised. Ten bit decisions follow, most significant bit first. In each decision the block presents a trial code to the comparator and reads back one comparator bit.

The controller has three states: STOP, STBY and CONV. It reports them as `state_o = {start, enable}`: STOP is 00, STBY is 01 and CONV is 11. The code 10 is prohibited and never appears. The transitions are:
- STOP→STBY when enable is high.
- STOP→CONV when enable is high and a start of 1 is written in the same cycle.
- STBY→CONV when a start of 1 is written.
- STBY→STOP and CONV→STOP when enable falls.
- CONV→STBY when the conversion completes, or when a start of 0 is written.

When the conversion completes, the start bit clears, a one-cycle done pulse is raised and the result register is loaded. A start written too soon after enable rises taints that conversion and raises a sticky invalid flag. A start of 1 written while enable is low is ignored and raises a sticky error bit.

Top module: `adc_seq_top`

## Requirements
- R1: `state_o` reads 00 in STOP, 01 in STBY and 11 in CONV. It never reads 10. It reads 00 after reset.
- R2: Divider select 00, 01, 10 and 11 gives 8, 4, 2 and 1 system clocks per conversion clock.
- R3: With `fast_i`=0 a conversion lasts 23 conversion clocks, and `sample_o` is high for the first 9 of them. With `fast_i`=1 it lasts 17 conversion clocks, and `sample_o` is high for the first 3. A conversion lasts total × ratio system clocks, counted from the clock edge that accepts the start to the edge that raises `done_o`.
- R4: Bit decisions run MSB first, in the 10 conversion clocks that follow sampling. Each decision starts with the bit under test set in `trial_o`. `cmp_i`=1 keeps that bit and `cmp_i`=0 clears it. With a comparator that returns (input code ≥ `trial_o`), `result_o` equals the input code.
- R5: When a conversion completes, `done_o` is high for exactly one cycle. `result_o` updates in that same cycle, and `state_o` becomes 01 (the start bit has cleared). `result_o` changes at no other time.
- R6: Writing start=0 during CONV returns the block to STBY without a done pulse and leaves `result_o` unchanged. This holds even when the write falls in the final system clock of the conversion.
- R7: When enable is low, the next state is STOP. A conversion in progress is abandoned, with no done pulse and no change to the result.
- R8: A start=1 write while enable is low leaves the state at STOP and sets `start_err_o`. That bit stays set until reset.
- R9: A start accepted after fewer than SETTLE_CYC consecutive enabled clock edges sets `first_bad_o`. A start accepted after exactly SETTLE_CYC such edges does not set it.
- R10: `first_bad_o` stays set when a tainted conversion completes. It clears when a conversion that was accepted after settling completes.
- R11: The divider select and speed select are captured when a start is accepted. Changing them during a conversion has no effect on its timing.
- R12: A start=1 write during CONV is ignored. The conversion neither restarts nor lengthens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Converter enable level |
| start_wr_i | input | 1 | Write strobe for the start bit |
| start_val_i | input | 1 | Value written to the start bit |
| div_sel_i | input | 2 | Conversion-clock divider select |
| fast_i | input | 1 | Speed select: 0 = 23-clock conversion, 1 = 17-clock conversion |
| cmp_i | input | 1 | Comparator decision (1 = input at or above trial code) |
| sample_o | output | 1 | Sampling strobe to the front end |
| trial_o | output | 10 | Trial code presented to the comparator |
| result_o | output | 10 | Last completed conversion result |
| done_o | output | 1 | One-cycle completion pulse |
| state_o | output | 2 | {start, enable} state code |
| first_bad_o | output | 1 | Sticky flag: first result taken before settling |
| start_err_o | output | 1 | Sticky flag: start written while disabled |

## Verification
A software write of start=0 and the conversion's own completion can fall in the same system clock. In that case the abort must win: no done pulse, an unchanged result and the STBY state. The bench provokes this at the fastest timing (undivided clock, 17-clock mode). It counts system clocks from the accepting edge and drives the clearing write so that it is captured on the 17th edge, the one that would otherwise complete the conversion. Over the following cycles it checks that `done_o` stays low and that `result_o` still holds the previous code.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'b00,
        ST_STBY = 2'b01,
        ST_CONV = 2'b11
    } seq_state_e;

    function automatic logic [3:0] div_ratio(input logic [1:0] sel);
        logic [3:0] r;
        unique case (sel)
            2'b00:   r = 4'd8;
            2'b01:   r = 4'd4;
            2'b10:   r = 4'd2;
            default: r = 4'd1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/adc_seq_prescale.sv
module adc_seq_prescale
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [3:0] cnt_q;
    logic [3:0] ratio;

    assign ratio = div_ratio(sel);
    assign tick  = run && (cnt_q == ratio - 4'd1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 4'd1;
    end
endmodule

// File: rtl/adc_seq_settle.sv
module adc_seq_settle #(
    parameter int SETTLE_CYC = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic settled
);
    localparam int CW = $clog2(SETTLE_CYC + 1);

    logic [CW-1:0] cnt_q;

    assign settled = (cnt_q == CW'(SETTLE_CYC));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!enable)
            cnt_q <= '0;
        else if (!settled)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/adc_seq_sar.sv
module adc_seq_sar #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic                cmp,
    output logic [RES_BITS-1:0] trial
);
    localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

    logic [RES_BITS-1:0] trial_q;
    logic [RES_BITS-1:0] ptr_q;

    assign trial = trial_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q <= '0;
            ptr_q   <= '0;
        end else if (load) begin
            trial_q <= TOP_BIT;
            ptr_q   <= TOP_BIT;
        end else if (step) begin
            trial_q <= (cmp ? trial_q : (trial_q & ~ptr_q)) | (ptr_q >> 1);
            ptr_q   <= ptr_q >> 1;
        end
    end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
    import adc_seq_pkg::*;
#(
    parameter int RES_BITS     = 10,
    parameter int SETTLE_CYC   = 25,
    parameter int LONG_TOTAL   = 23,
    parameter int LONG_SAMPLE  = 9,
    parameter int SHORT_TOTAL  = 17,
    parameter int SHORT_SAMPLE = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable_i,
    input  logic                start_wr_i,
    input  logic                start_val_i,
    input  logic [1:0]          div_sel_i,
    input  logic                fast_i,
    input  logic                cmp_i,
    output logic                sample_o,
    output logic [RES_BITS-1:0] trial_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                done_o,
    output logic [1:0]          state_o,
    output logic                first_bad_o,
    output logic                start_err_o
);
    localparam int PH_W = $clog2(LONG_TOTAL + 1);

    seq_state_e st_q, st_d;

    logic [PH_W-1:0]     phase_q;
    logic [1:0]          sel_q;
    logic                mode_q;
    logic                done_q;
    logic [RES_BITS-1:0] result_q;
    logic                bad_q;
    logic                taint_q;
    logic                err_q;

    logic wr_one, wr_zero, accept, conv, tick, settled, last_tick, finish, step;
    logic [PH_W-1:0] tot_m1, samp_n, dec_end;

    assign wr_one  = start_wr_i && start_val_i;
    assign wr_zero = start_wr_i && !start_val_i;
    assign conv    = (st_q == ST_CONV);
    assign accept  = !conv && enable_i && wr_one;

    assign tot_m1  = mode_q ? PH_W'(SHORT_TOTAL - 1) : PH_W'(LONG_TOTAL - 1);
    assign samp_n  = mode_q ? PH_W'(SHORT_SAMPLE)    : PH_W'(LONG_SAMPLE);
    assign dec_end = samp_n + PH_W'(RES_BITS);

    assign last_tick = conv && tick && (phase_q == tot_m1);
    assign finish    = last_tick && enable_i && !wr_zero;
    assign step      = conv && tick && (phase_q >= samp_n) && (phase_q < dec_end);

    adc_seq_prescale u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (conv),
        .sel   (sel_q),
        .tick  (tick)
    );

    adc_seq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable_i),
        .settled (settled)
    );

    adc_seq_sar #(.RES_BITS(RES_BITS)) u_sar (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (step),
        .cmp   (cmp_i),
        .trial (trial_o)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_STOP: begin
                if (accept)        st_d = ST_CONV;
                else if (enable_i) st_d = ST_STBY;
            end
            ST_STBY: begin
                if (!enable_i)     st_d = ST_STOP;
                else if (accept)   st_d = ST_CONV;
            end
            ST_CONV: begin
                if (!enable_i)                 st_d = ST_STOP;
                else if (wr_zero || last_tick) st_d = ST_STBY;
            end
            default: st_d = ST_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_STOP;
        else        st_q <= st_d;
    end

    // conversion datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= '0;
            sel_q    <= '0;
            mode_q   <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
            bad_q    <= 1'b0;
            taint_q  <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                phase_q <= '0;
                sel_q   <= div_sel_i;
                mode_q  <= fast_i;
                taint_q <= !settled;
                if (!settled) bad_q <= 1'b1;
            end else if (conv && tick) begin
                phase_q <= phase_q + 1'b1;
            end
            if (finish) begin
                result_q <= trial_o;
                if (!taint_q) bad_q <= 1'b0;
            end
            if (wr_one && !enable_i) err_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        sample_o    = conv && (phase_q < samp_n);
        state_o     = st_q;
        done_o      = done_q;
        result_o    = result_q;
        first_bad_o = bad_q;
        start_err_o = err_q;
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable_i,
    input logic                start_wr_i,
    input logic                start_val_i,
    input logic                sample_o,
    input logic                done_o,
    input logic [1:0]          state_o,
    input logic [RES_BITS-1:0] result_o,
    input logic                start_err_o
);
    p_legal_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state_o != 2'b10);

    p_sample_in_conv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> state_o == 2'b11);

    p_done_ends_conv_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_o == 2'b01 && $past(state_o) == 2'b11));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_result_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> done_o);

    p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'b11 && enable_i && start_wr_i && !start_val_i)
        |=> (state_o == 2'b01 && !done_o));

    p_disable_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> state_o == 2'b00);

    p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr_i && start_val_i && !enable_i) |=> start_err_o);

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_err_o |=> start_err_o);
endmodule

bind adc_seq_top adc_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable_i    (enable_i),
    .start_wr_i  (start_wr_i),
    .start_val_i (start_val_i),
    .sample_o    (sample_o),
    .done_o      (done_o),
    .state_o     (state_o),
    .result_o    (result_o),
    .start_err_o (start_err_o)
);

// File: tb/sim_adc_seq_top.sv
`timescale 1ns/1ps
module sim_adc_seq_top;
    localparam int S = 25;

    logic       clk = 1'b0;
    logic       rst_n, en, wr, wv, mode, cmp;
    logic [1:0] sel;
    logic [9:0] code;
    logic       sample, done, bad, err;
    logic [9:0] trial, res;
    logic [1:0] st;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    assign cmp = (code >= trial);

    adc_seq_top #(.SETTLE_CYC(S)) u0 (
        .clk (clk), .rst_n (rst_n), .enable_i (en), .start_wr_i (wr),
        .start_val_i (wv), .div_sel_i (sel), .fast_i (mode), .cmp_i (cmp),
        .sample_o (sample), .trial_o (trial), .result_o (res), .done_o (done),
        .state_o (st), .first_bad_o (bad), .start_err_o (err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_start(input logic v);
        @(negedge clk);
        wr = 1'b1; wv = v;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic run_conv(input logic [1:0] s, input logic m, input logic [9:0] c,
                            input bit disturb, input bit early);
        int n, tot, smp, cyc, scnt;
        n = 8 >> s; tot = m ? 17 : 23; smp = m ? 3 : 9;
        sel = s; mode = m; code = c;
        write_start(1'b1);
        chk(st == 2'b11, "R1 converting code", st, 3);
        if (early) chk(bad == 1'b1, "R9 early start flagged", bad, 1);
        cyc = 0; scnt = 0;
        while (!done && cyc < 600) begin
            if (sample) scnt++;
            if (disturb && cyc == 3) begin sel = ~s; mode = ~m; end
            if (disturb && cyc == 5) begin wr = 1'b1; wv = 1'b1; end
            if (disturb && cyc == 6) wr = 1'b0;
            @(negedge clk);
            cyc++;
        end
        chk(cyc == tot * n, disturb ? "R11 R12 length unaffected" : "R2 R3 length",
            cyc, tot * n);
        chk(scnt == smp * n, "R3 sampling window", scnt, smp * n);
        chk(res == c, "R4 result code", res, c);
        chk(st == 2'b01, "R5 start cleared", st, 1);
        chk(bad == early, "R10 invalid flag at end", bad, early);
        @(negedge clk);
        chk(done == 1'b0, "R5 done one cycle", done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [9:0] prev;
        int cyc;
        bit seen;
        logic [9:0] pats [6];
        pats = '{10'd0, 10'd1023, 10'h2AA, 10'h155, 10'h200, 10'h1FF};
        rst_n = 1'b0; en = 1'b0; wr = 1'b0; wv = 1'b0;
        sel = 2'b00; mode = 1'b0; code = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(st == 2'b00, "R1 reset state", st, 0);
        chk(done == 1'b0 && res == 0, "R5 reset outputs", res, 0);
        chk(bad == 1'b0 && err == 1'b0, "R8 reset flags", err, 0);

        // R8: start while disabled is ignored
        write_start(1'b1);
        chk(st == 2'b00, "R8 start ignored", st, 0);
        chk(err == 1'b1, "R8 error set", err, 1);

        en = 1'b1;
        repeat (S + 2) @(negedge clk);
        chk(st == 2'b01, "R1 standby code", st, 1);

        // R2 R3 R4 R5 sweep
        for (int s = 0; s < 4; s++)
            for (int m = 0; m < 2; m++)
                for (int p = 0; p < 6; p++)
                    run_conv(2'(s), 1'(m), pats[p], 1'b0, 1'b0);

        // R11 R12
        run_conv(2'b01, 1'b0, 10'h3C5, 1'b1, 1'b0);
        run_conv(2'b10, 1'b1, 10'h03A, 1'b1, 1'b0);

        // R6: abort coincides with the final conversion clock
        prev = res;
        sel = 2'b11; mode = 1'b1; code = 10'h0F0;
        write_start(1'b1);
        for (int i = 0; i < 16; i++) @(negedge clk);
        wr = 1'b1; wv = 1'b0;
        @(negedge clk);
        wr = 1'b0;
        chk(st == 2'b01, "R6 abort to standby", st, 1);
        seen = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (done) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R6 no done after abort", seen, 0);
        chk(res == prev, "R6 result kept", res, prev);

        // R7: enable drops mid conversion
        sel = 2'b00; mode = 1'b0; code = 10'h111;
        write_start(1'b1);
        repeat (10) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(st == 2'b00, "R7 stopped", st, 0);
        seen = 1'b0;
        for (int i = 0; i < 200; i++) begin
            if (done) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R7 no done", seen, 0);
        chk(res == prev, "R7 result kept", res, prev);

        // R9 R10: start one edge before settling
        en = 1'b1;
        repeat (S - 2) @(negedge clk);
        run_conv(2'b11, 1'b1, 10'h155, 1'b0, 1'b1);
        // clean conversion clears the flag
        run_conv(2'b11, 1'b1, 10'h2AA, 1'b0, 1'b0);
        // boundary: exactly S enabled edges is clean
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (S - 2) @(negedge clk);
        run_conv(2'b10, 1'b1, 10'h0C3, 1'b0, 1'b1);
        en = 1'b0;
        @(negedge clk);
        en = 1'b1;
        repeat (S - 1) @(negedge clk);
        run_conv(2'b11, 1'b0, 10'h321, 1'b0, 1'b0);

        cyc = 0;
        chk(err == 1'b1, "R8 error still sticky", err, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule